// File: doc/BRIEF.md
# Timer Capture and Counter-Reset Unit

This block pairs a free-running up-counter with an edge-driven event unit fed by a single-bit comparator input. The input is synchronized and turned into one-cycle edge events. A control word then decides what each event does. It can latch the running count into a capture register, clear the counter, or measure the interval between a pair of trigger edges.

Three of the unit's states can be seen from outside. A capture register holds the last latched count. A sticky event flag is cleared by writing 1 to it. An interrupt line follows the flag when interrupts are enabled. A small word-wide register port with a combinational read path gives access to the control word, the flag, the capture value and the live count.

Top module: `tcap_timer_capture`

## Requirements
- R1: After reset the counter, the control word, the event flag, the capture register and `irq` are all 0.
- R2: The counter adds 1 on every clock unless an event clears it, and it wraps from all-ones to 0.
- R3: `cmp_in` passes through two synchronizer flops and one previous-sample flop. An input change made before clock edge E1 acts at edge E3. The action uses the count held just before E3. Edge-select (control bits 2:1) picks the edge: 00 acts on 1-to-0, 01 acts on 0-to-1 and 10 acts on either.
- R4: With control bit 8 (trigger mode) = 0 and bit 4 (clear function) = 0, an event copies the count into the capture register and the counter keeps counting.
- R5: With bit 8 = 0 and bit 4 = 1, an event clears the counter to 0 and leaves the capture register unchanged.
- R6: With bit 8 = 1 and bit 4 = 0, events come in pairs. The first event clears the counter and arms the unit without setting the flag. The second event captures the count, does not clear the counter, and disarms the unit. The event after that starts a new pair.
- R7: No capture, clear, arming or flag activity happens when enable (control bit 3) is 0, when edge-select is 11, or when bits 8 and 4 are both 1.
- R8: Each capture or clear action sets the event flag. The flag stays set until software clears it.
- R9: Writing 1 to status bit 0 (address 1) clears the flag, and writing 0 there does nothing. If an event arrives in the same cycle as the clear, the flag stays set.
- R10: `irq` is high exactly while the flag is set and interrupt enable (control bit 5) is 1.
- R11: The register map is: address 0 is control, address 1 is status, address 2 is capture and address 3 is count. Control keeps bits 8, 5, 4, 3, 2:1 and reads 0 in all other bits. Reads are combinational.
- R12: Leaving trigger mode drops the armed state, so the first event after re-entering it counts as the first of a pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_in | input | 1 | Asynchronous comparator level |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address for read and write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data |
| irq | output | 1 | Interrupt request |

## Verification
The bench times every action against the three-flop input path. If that latency is wrong, each capture value it expects (count read at the toggle plus two) is off by one or more. In trigger mode it checks the pairing directly: the first edge must zero the counter without raising the flag, the second must hold the interval minus one and leave the counter running, and a mode change must discard a pending arm. A design that held the arm would capture early instead of clearing. The bench also places a status clear in exactly the event's cycle. A design that gave the clear priority would read back a cleared flag there. Finally it checks that the edges ignored by edge-select, the disabled cases and the undefined mode leave the count, the flag and the capture register untouched.

// File: rtl/tcap_pkg.sv
package tcap_pkg;

  localparam int unsigned SYNC_DEPTH = 2;
  localparam int unsigned REG_W      = 32;

  localparam int unsigned CTRL_EDGE_LSB  = 1;
  localparam int unsigned CTRL_ENABLE    = 3;
  localparam int unsigned CTRL_CLR_FUNC  = 4;
  localparam int unsigned CTRL_IRQ_EN    = 5;
  localparam int unsigned CTRL_TRIG_MODE = 8;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_STAT = 2'd1;
  localparam logic [1:0] ADDR_CAPT = 2'd2;
  localparam logic [1:0] ADDR_CNT  = 2'd3;

  typedef enum logic [1:0] {
    EDGE_FALL = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_BOTH = 2'b10,
    EDGE_NONE = 2'b11
  } edge_sel_e;

  typedef struct packed {
    logic      trig_mode;
    logic      irq_en;
    logic      clr_func;
    logic      enable;
    edge_sel_e edge_sel;
  } ctrl_t;

  function automatic ctrl_t ctrl_from_word(input logic [REG_W-1:0] w);
    ctrl_t c;
    c.trig_mode = w[CTRL_TRIG_MODE];
    c.irq_en    = w[CTRL_IRQ_EN];
    c.clr_func  = w[CTRL_CLR_FUNC];
    c.enable    = w[CTRL_ENABLE];
    c.edge_sel  = edge_sel_e'(w[CTRL_EDGE_LSB +: 2]);
    return c;
  endfunction

  function automatic logic [REG_W-1:0] ctrl_to_word(input ctrl_t c);
    logic [REG_W-1:0] w;
    w = '0;
    w[CTRL_TRIG_MODE]      = c.trig_mode;
    w[CTRL_IRQ_EN]         = c.irq_en;
    w[CTRL_CLR_FUNC]       = c.clr_func;
    w[CTRL_ENABLE]         = c.enable;
    w[CTRL_EDGE_LSB +: 2]  = c.edge_sel;
    return w;
  endfunction

endpackage

// File: rtl/tcap_edge_det.sv
module tcap_edge_det
  import tcap_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      din,
  input  edge_sel_e edge_sel,
  output logic      hit
);

  localparam int unsigned CHAIN = SYNC_DEPTH + 1;

  logic [CHAIN-1:0] sync_q;
  logic [CHAIN-1:0] sync_d;
  logic             rise;
  logic             fall;

  always_comb begin
    sync_d[0] = din;
    for (int i = 1; i < CHAIN; i++) begin
      sync_d[i] = sync_q[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rise = sync_q[CHAIN-2] & ~sync_q[CHAIN-1];
  assign fall = ~sync_q[CHAIN-2] & sync_q[CHAIN-1];

  always_comb begin
    unique case (edge_sel)
      EDGE_FALL: hit = fall;
      EDGE_RISE: hit = rise;
      EDGE_BOTH: hit = rise | fall;
      default:   hit = 1'b0;
    endcase
  end

  // cycles since reset, used to qualify the history check below
  logic [1:0] warm_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              warm_q <= '0;
    else if (warm_q != 2'd3) warm_q <= warm_q + 2'd1;
  end

  // R3: an event needs an input change two and three samples back
  a_r3_hit_from_input_change: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && warm_q == 2'd3) |-> ($past(din, 2) != $past(din, 3)));

  // R3: the reserved selector never yields an event
  a_r3_none_is_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_sel == EDGE_NONE) |-> !hit);

endmodule

// File: rtl/tcap_counter.sv
module tcap_counter #(
  parameter int unsigned CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  output logic [CNT_W-1:0] cnt_q
);

  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    if (clr) cnt_d = '0;
    else     cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R2: wrap from all-ones to zero
  a_r2_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '1 && !clr) |=> (cnt_q == '0));

  // R2: steady increment
  a_r2_increment: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> (cnt_q == $past(cnt_q) + 1'b1));

endmodule

// File: rtl/tcap_event_ctl.sv
module tcap_event_ctl #(
  parameter int unsigned CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hit,
  input  logic             enable,
  input  logic             trig_mode,
  input  logic             clr_func,
  input  logic             sts_clr,
  input  logic [CNT_W-1:0] cnt_q,
  output logic             cnt_clr,
  output logic [CNT_W-1:0] cap_q,
  output logic             flag_q
);

  logic do_cap;
  logic set_flag;
  logic arm_q;
  logic arm_d;
  logic flag_d;
  logic trig_active;

  assign trig_active = enable & trig_mode & ~clr_func;

  always_comb begin
    do_cap   = 1'b0;
    cnt_clr  = 1'b0;
    set_flag = 1'b0;
    arm_d    = trig_active ? arm_q : 1'b0;
    if (enable && hit) begin
      unique case ({trig_mode, clr_func})
        2'b00: begin
          do_cap   = 1'b1;
          set_flag = 1'b1;
        end
        2'b01: begin
          cnt_clr  = 1'b1;
          set_flag = 1'b1;
        end
        2'b10: begin
          if (!arm_q) begin
            cnt_clr = 1'b1;
            arm_d   = 1'b1;
          end else begin
            do_cap   = 1'b1;
            set_flag = 1'b1;
            arm_d    = 1'b0;
          end
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    if (set_flag)     flag_d = 1'b1;
    else if (sts_clr) flag_d = 1'b0;
    else              flag_d = flag_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arm_q  <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      arm_q  <= arm_d;
      flag_q <= flag_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cap_q <= '0;
    else if (do_cap) cap_q <= cnt_q;
  end

  // R4: capture takes the count seen in the event cycle
  a_r4_capture_value: assert property (@(posedge clk) disable iff (!rst_n)
    do_cap |=> (cap_q == $past(cnt_q)));

  // R7: with enable low nothing is captured and the flag cannot rise
  a_r7_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> ($stable(cap_q) && !$rose(flag_q)));

  // R6: second trigger of a pair measures without clearing
  a_r6_second_no_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && arm_q && trig_active) |-> !cnt_clr);

  // R8: flag is sticky without a clear
  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !sts_clr) |=> flag_q);

  // R9: a clear without a coincident event drops the flag
  a_r9_w1c: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_clr && !set_flag) |=> !flag_q);

  // R9: a coincident event wins over the clear
  a_r9_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
    set_flag |=> flag_q);

endmodule

// File: rtl/tcap_timer_capture.sv
module tcap_timer_capture
  import tcap_pkg::*;
#(
  parameter int unsigned CNT_W = 24
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmp_in,
  input  logic        reg_wr,
  input  logic [1:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        irq
);

  ctrl_t            ctrl_q;
  logic             ctrl_we;
  logic             sts_clr;
  logic             hit;
  logic             cnt_clr;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cap_q;
  logic             flag_q;
  logic             wdata_unused;

  assign ctrl_we      = reg_wr && (reg_addr == ADDR_CTRL);
  assign sts_clr      = reg_wr && (reg_addr == ADDR_STAT) && reg_wdata[0];
  assign wdata_unused = ^{reg_wdata[31:9], reg_wdata[7:6]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (ctrl_we) ctrl_q <= ctrl_from_word(reg_wdata);
  end

  tcap_edge_det u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .din      (cmp_in),
    .edge_sel (ctrl_q.edge_sel),
    .hit      (hit)
  );

  tcap_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (cnt_clr),
    .cnt_q (cnt_q)
  );

  tcap_event_ctl #(.CNT_W(CNT_W)) u_evt (
    .clk       (clk),
    .rst_n     (rst_n),
    .hit       (hit),
    .enable    (ctrl_q.enable),
    .trig_mode (ctrl_q.trig_mode),
    .clr_func  (ctrl_q.clr_func),
    .sts_clr   (sts_clr),
    .cnt_q     (cnt_q),
    .cnt_clr   (cnt_clr),
    .cap_q     (cap_q),
    .flag_q    (flag_q)
  );

  always_comb begin
    unique case (reg_addr)
      ADDR_CTRL: reg_rdata = ctrl_to_word(ctrl_q);
      ADDR_STAT: reg_rdata = {31'd0, flag_q};
      ADDR_CAPT: reg_rdata = 32'(cap_q);
      default:   reg_rdata = 32'(cnt_q);
    endcase
  end

  assign irq = flag_q & ctrl_q.irq_en;

  // R5: a clear action leaves the counter at zero on the next cycle
  a_r5_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_clr |=> (cnt_q == '0));

  // R10: the interrupt can only rise while the flag is set
  a_r10_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> flag_q);

  // R10: interrupt is silent when its enable is low
  a_r10_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q.irq_en |-> !irq);

endmodule

// File: tb/tb_tcap_timer_capture.sv
`timescale 1ns/1ps
module tb_tcap_timer_capture;

  localparam int unsigned W    = 8;
  localparam logic [31:0] MASK = (32'd1 << W) - 32'd1;

  logic        clk;
  logic        rst_n;
  logic        cmp_in;
  logic        reg_wr;
  logic [1:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        irq;

  int n_cmp;
  int n_bad;
  bit done;

  tcap_timer_capture #(.CNT_W(W)) dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmp_in    (cmp_in),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .irq       (irq)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    reg_addr = a;
    #0.1;
    d = reg_rdata;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic clear_flag();
    wr(2'd1, 32'd1);
  endtask

  task automatic toggle();
    cmp_in = ~cmp_in;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rst_n = 1'b0; cmp_in = 1'b0; reg_wr = 1'b0; reg_addr = 2'd0; reg_wdata = '0;
    step(3);
    rd(2'd3, v); chk("R1 count in reset", v, 32'd0);
    rst_n = 1'b1;
    rd(2'd0, v); chk("R1 control", v, 32'd0);
    rd(2'd1, v); chk("R1 flag", v, 32'd0);
    rd(2'd2, v); chk("R1 capture", v, 32'd0);
    chk("R1 irq", {31'd0, irq}, 32'd0);
  endtask

  task automatic t_free_run();
    logic [31:0] c, v;
    step(1);
    rd(2'd3, c); step(5); rd(2'd3, v);
    chk("R2 increment", v, (c + 32'd5) & MASK);
    for (int i = 0; i < 400; i++) begin
      rd(2'd3, v);
      if (v == MASK) break;
      step(1);
    end
    chk("R2 reached all-ones", v, MASK);
    step(1); rd(2'd3, v);
    chk("R2 wrap to zero", v, 32'd0);
  endtask

  // capture under one selector: expect capture on a chosen toggle
  task automatic capture_edge(input string req, input logic [31:0] ctrl, input bit expect_act);
    logic [31:0] c, cap0, v;
    wr(2'd0, ctrl);
    clear_flag();
    rd(2'd2, cap0);
    rd(2'd3, c);
    toggle();
    step(3);
    rd(2'd2, v);
    chk(req, v, expect_act ? ((c + 32'd2) & MASK) : cap0);
    rd(2'd1, v);
    chk(req, v, expect_act ? 32'd1 : 32'd0);
    rd(2'd3, v);
    chk("R4 counter keeps running", v, (c + 32'd3) & MASK);
  endtask

  task automatic t_free_capture();
    // rise only (01): cmp is 0, first toggle rises
    capture_edge("R4 R3 R8 rise capture", 32'h00A, 1'b1);
    capture_edge("R3 falling ignored under rise", 32'h00A, 1'b0);
    // fall only (00)
    capture_edge("R3 rising ignored under fall", 32'h008, 1'b0);
    capture_edge("R3 fall capture", 32'h008, 1'b1);
    // either (10)
    capture_edge("R3 both rise", 32'h00C, 1'b1);
    capture_edge("R3 both fall", 32'h00C, 1'b1);
  endtask

  task automatic t_reset_mode();
    logic [31:0] cap0, v;
    wr(2'd0, 32'h01C);
    clear_flag();
    rd(2'd2, cap0);
    toggle();
    step(3);
    rd(2'd3, v); chk("R5 counter cleared", v, 32'd0);
    rd(2'd1, v); chk("R8 flag from clear", v, 32'd1);
    rd(2'd2, v); chk("R5 capture unchanged", v, cap0);
    step(1);
    rd(2'd3, v); chk("R5 counts on after clear", v, 32'd1);
  endtask

  task automatic trig_pair(input int n);
    logic [31:0] v;
    toggle();
    step(3);
    rd(2'd3, v); chk("R6 first edge clears", v, 32'd0);
    rd(2'd1, v); chk("R6 first edge no flag", v, 32'd0);
    step(n - 3);
    toggle();
    step(3);
    rd(2'd2, v); chk("R6 measured interval", v, 32'(n - 1));
    rd(2'd1, v); chk("R6 R8 second edge flag", v, 32'd1);
    rd(2'd3, v); chk("R6 second edge no clear", v, 32'(n));
    clear_flag();
  endtask

  task automatic t_trigger();
    wr(2'd0, 32'h10C);
    clear_flag();
    trig_pair(20);
    trig_pair(10);
  endtask

  task automatic t_disarm();
    logic [31:0] v;
    wr(2'd0, 32'h10C);
    clear_flag();
    toggle();
    step(3);
    rd(2'd3, v); chk("R12 armed by first edge", v, 32'd0);
    wr(2'd0, 32'h000);
    wr(2'd0, 32'h10C);
    toggle();
    step(3);
    rd(2'd1, v); chk("R12 re-entry starts new pair (no flag)", v, 32'd0);
    rd(2'd3, v); chk("R12 re-entry clears", v, 32'd0);
    toggle();
    step(3);
    clear_flag();
  endtask

  task automatic quiet_case(input string req, input logic [31:0] ctrl);
    logic [31:0] c, cap0, v;
    wr(2'd0, ctrl);
    clear_flag();
    rd(2'd2, cap0);
    rd(2'd3, c);
    toggle();
    step(3);
    rd(2'd3, v); chk(req, v, (c + 32'd3) & MASK);
    rd(2'd1, v); chk(req, v, 32'd0);
    rd(2'd2, v); chk(req, v, cap0);
  endtask

  task automatic t_ignored();
    quiet_case("R7 enable low", 32'h014);
    quiet_case("R7 selector 11", 32'h01E);
    quiet_case("R7 mode 8 and 4 both set", 32'h11C);
  endtask

  task automatic t_w1c();
    logic [31:0] v;
    wr(2'd0, 32'h00C);
    clear_flag();
    toggle();
    step(3);
    rd(2'd1, v); chk("R8 flag set", v, 32'd1);
    wr(2'd1, 32'd0);
    rd(2'd1, v); chk("R9 write 0 keeps flag", v, 32'd1);
    step(2);
    rd(2'd1, v); chk("R8 flag sticky", v, 32'd1);
    clear_flag();
    rd(2'd1, v); chk("R9 write 1 clears", v, 32'd0);
    // clear lands on the event edge
    toggle();
    step(2);
    reg_wr = 1'b1; reg_addr = 2'd1; reg_wdata = 32'd1;
    @(negedge clk);
    reg_wr = 1'b0;
    rd(2'd1, v); chk("R9 event beats clear", v, 32'd1);
  endtask

  task automatic t_irq();
    logic [31:0] v;
    rd(2'd1, v); chk("R10 flag precondition", v, 32'd1);
    chk("R10 masked", {31'd0, irq}, 32'd0);
    wr(2'd0, 32'h02C);
    chk("R10 enabled with flag", {31'd0, irq}, 32'd1);
    clear_flag();
    chk("R10 low after clear", {31'd0, irq}, 32'd0);
  endtask

  task automatic t_regmap();
    logic [31:0] v;
    wr(2'd0, 32'hFFFF_FFFF);
    rd(2'd0, v); chk("R11 control readback", v, 32'h13E);
    wr(2'd0, 32'h0000_0000);
    rd(2'd0, v); chk("R11 control cleared", v, 32'd0);
  endtask

  initial begin
    n_cmp = 0; n_bad = 0; done = 1'b0;
    t_reset();
    t_free_run();
    t_free_capture();
    t_reset_mode();
    t_trigger();
    t_disarm();
    t_ignored();
    t_w1c();
    t_irq();
    t_regmap();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog R1..all actual=running expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule